// File: doc/BRIEF.md
# Transmit Cell Path Control and Interrupt Status Register

This block is one 8-bit register on the transmit side of a cell-based link. A simple processor bus reaches it with an address, separate read and write strobes, and write and read data. Software uses it for four things. It can restart the transmit FIFO by setting a command bit. It can choose whether cells that fail the parity check are dropped. It can enable each of three interrupt sources on its own. It can poll and acknowledge three sticky event flags.

The transmit path sends three single-cycle event pulses into the block: a parity error, a FIFO overrun and a runt (misaligned) cell. Each pulse sets its sticky flag. Any flag whose enable is set drives the level interrupt request. Reading the register returns its contents and clears the flags. All of this works only while the mode input selects cell operation. In the other mode, events are ignored, no FIFO restart pulse is issued, and the discard and interrupt outputs stay low.

Top module: `txcell_irq_reg`

## Requirements
- R1: After reset every bit of the register is 0. The register responds only at address 0x6E. After reset, irq, fifo_rst_pulse and discard_on_perr are all low.
- R2: In cell mode, a write to bit 7 that changes it from 0 to 1 produces fifo_rst_pulse high for exactly the one clock cycle that follows the write. Writing 1 while bit 7 already holds 1 produces no pulse. Bit 7 reads back its stored value.
- R3: Bit 6 holds the parity discard policy. While cell mode is selected, discard_on_perr equals bit 6.
- R4: Bits 5, 4 and 3 are read/write enables for the parity-error, FIFO-overrun and runt-cell interrupts, in that order.
- R5: Bits 2, 1 and 0 are sticky flags for the parity-error, FIFO-overrun and runt-cell events, in that order. In cell mode, an event pulse sets its flag on the next clock edge. A read of the register returns the flags and clears them at the end of that read cycle.
- R6: The status bits 2 to 0 cannot be written. Writes to them are ignored.
- R7: irq is high in cell mode whenever any flag is set together with its enable. It stays high until a read clears the flag.
- R8: An event that arrives in the same cycle as a read of the register keeps its flag set after that read. The read itself returns the value the flag had before the event.
- R9: Outside cell mode, events set no flag, no FIFO reset pulse is produced, and discard_on_perr and irq are low. Writes still store bits 7 to 3.
- R10: A read or write at any other address leaves the register unchanged and does not clear the flags. During that access, bus_rdata is zero.
- R11: bus_rdata is zero whenever no read of address 0x6E is in progress. During such a read it shows the eight bits in the layout above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_mode | input | 1 | 1 selects cell operation; 0 disables every function |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during a read |
| ev_parity | input | 1 | Parity error event pulse |
| ev_overrun | input | 1 | FIFO overrun event pulse |
| ev_runt | input | 1 | Runt cell event pulse |
| fifo_rst_pulse | output | 1 | One-cycle transmit FIFO reset command |
| discard_on_perr | output | 1 | Drop cells that fail the parity check |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can fall on the same clock edge: the clear caused by a register read, and the set caused by an event pulse. The bench provokes this by holding the read strobe and the parity event in the same cycle while a different flag is already pending. The read must return only the older flag. A second read must then show the parity flag still set, and the older flag cleared. A single-source event sweep over every enable pattern runs alongside, so that the set path and the clear path are each observed on their own before they are combined.

// File: rtl/txcell_irq_pkg.sv
package txcell_irq_pkg;
  localparam int NSRC     = 3;
  localparam int DW       = 8;
  localparam int BIT_FRST = 7;
  localparam int BIT_DISC = 6;
  localparam int EN_LSB   = 3;
  localparam int STS_LSB  = 0;

  function automatic logic any_pending(input logic [NSRC-1:0] sts,
                                       input logic [NSRC-1:0] en);
    return |(sts & en);
  endfunction

  function automatic logic cmd_rises(input logic old_v, input logic new_v);
    return !old_v && new_v;
  endfunction

  function automatic logic [DW-1:0] pack_reg(input logic frst, input logic disc,
                                             input logic [NSRC-1:0] en,
                                             input logic [NSRC-1:0] sts);
    return {frst, disc, en, sts};
  endfunction
endpackage

// File: rtl/txcell_bus_decode.sv
module txcell_bus_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h6E
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic              rd_hit,
  output logic              wr_hit
);
  logic addr_match;

  always_comb begin
    addr_match = (bus_addr == REG_ADDR);
    rd_hit     = bus_rd && addr_match;
    wr_hit     = bus_wr && addr_match;
  end
endmodule

// File: rtl/txcell_ctrl_bits.sv
module txcell_ctrl_bits
  import txcell_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cell_mode,
  input  logic            wr_hit,
  input  logic [DW-1:0]   wdata,
  output logic            frst_q,
  output logic            disc_q,
  output logic [NSRC-1:0] en_q,
  output logic            frst_pulse
);
  logic frst_rise;

  always_comb
    frst_rise = wr_hit && cell_mode && cmd_rises(frst_q, wdata[BIT_FRST]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frst_q     <= 1'b0;
      disc_q     <= 1'b0;
      en_q       <= '0;
      frst_pulse <= 1'b0;
    end else begin
      frst_pulse <= frst_rise;
      if (wr_hit) begin
        frst_q <= wdata[BIT_FRST];
        disc_q <= wdata[BIT_DISC];
        en_q   <= wdata[EN_LSB +: NSRC];
      end
    end
  end

  // R2: a reset pulse only comes with a stored 0-to-1 change of the command bit
  assert_pulse_needs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frst_pulse |-> $rose(frst_q));
  // R2: the pulse lasts one cycle
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frst_pulse |=> !frst_pulse);
  // R9: no pulse unless the write happened in cell mode
  assert_pulse_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frst_pulse |-> $past(cell_mode));
endmodule

// File: rtl/txcell_sticky.sv
module txcell_sticky
  import txcell_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cell_mode,
  input  logic            clr,
  input  logic [NSRC-1:0] ev,
  output logic [NSRC-1:0] sts_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic set_i;
    always_comb set_i = ev[i] && cell_mode;

    always_ff @(posedge clk) begin
      if (!rst_n)     sts_q[i] <= 1'b0;
      else if (set_i) sts_q[i] <= 1'b1;
      else if (clr)   sts_q[i] <= 1'b0;
    end

    // R5 and R8: an event in cell mode always leaves its flag set, even under a read
    assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && cell_mode) |=> sts_q[i]);
    // R5: a read without a new event clears the flag
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ev[i]) |=> !sts_q[i]);
    // R9: outside cell mode a clear flag stays clear
    assert_mode_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cell_mode && !sts_q[i]) |=> !sts_q[i]);
  end
endmodule

// File: rtl/txcell_irq_reg.sv
module txcell_irq_reg
  import txcell_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ev_parity,
  input  logic              ev_overrun,
  input  logic              ev_runt,
  output logic              fifo_rst_pulse,
  output logic              discard_on_perr,
  output logic              irq
);
  logic            rd_hit;
  logic            wr_hit;
  logic            frst_q;
  logic            disc_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] sts_q;
  logic [NSRC-1:0] ev_vec;

  always_comb ev_vec = {ev_parity, ev_overrun, ev_runt};

  txcell_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit)
  );

  txcell_ctrl_bits u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_mode  (cell_mode),
    .wr_hit     (wr_hit),
    .wdata      (bus_wdata),
    .frst_q     (frst_q),
    .disc_q     (disc_q),
    .en_q       (en_q),
    .frst_pulse (fifo_rst_pulse)
  );

  txcell_sticky u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_mode (cell_mode),
    .clr       (rd_hit),
    .ev        (ev_vec),
    .sts_q     (sts_q)
  );

  always_comb begin
    bus_rdata       = rd_hit ? pack_reg(frst_q, disc_q, en_q, sts_q) : '0;
    discard_on_perr = cell_mode && disc_q;
    irq             = cell_mode && any_pending(sts_q, en_q);
  end

  // R10: foreign reads return zero
  assert_foreign_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != REG_ADDR) |-> bus_rdata == '0);
  // R7: the request holds until the register is accessed or the mode drops
  assert_irq_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !bus_rd && !bus_wr) |=> (irq || !cell_mode));
endmodule

// File: tb/test_txcell_irq_reg.sv
module test_txcell_irq_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cell_mode = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ev_parity = 1'b0, ev_overrun = 1'b0, ev_runt = 1'b0;
  logic       fifo_rst_pulse, discard_on_perr, irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  localparam logic [7:0] REG = 8'h6E;

  always #10 clk = ~clk;

  txcell_irq_reg i_txcell_irq_reg (
    .clk(clk), .rst_n(rst_n), .cell_mode(cell_mode),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_parity(ev_parity), .ev_overrun(ev_overrun), .ev_runt(ev_runt),
    .fifo_rst_pulse(fifo_rst_pulse), .discard_on_perr(discard_on_perr), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output logic pulse);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    pulse = fifo_rst_pulse;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic fire(input logic [2:0] v);
    @(negedge clk);
    {ev_parity, ev_overrun, ev_runt} = v;
    @(negedge clk);
    {ev_parity, ev_overrun, ev_runt} = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 pulse", {7'd0, fifo_rst_pulse}, 8'd0);
    check("R1 discard", {7'd0, discard_on_perr}, 8'd0);
    rd(REG, d); check("R1 reg", d, 8'h00);
    // R11: idle read data is zero
    check("R11 idle rdata", bus_rdata, 8'h00);

    // R3 R4 R6: control sweep, with status bits written as 1
    for (int c = 0; c < 16; c++) begin
      wr(REG, {1'b0, c[3:0], 3'b111}, p);
      check("R3 discard", {7'd0, discard_on_perr}, {7'd0, c[3]});
      rd(REG, d);
      check("R4 R6 readback", d, {1'b0, c[3:0], 3'b000});
    end

    // R5 R7: every enable pattern against every single source
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 3; s++) begin
        logic [2:0] v;
        v = 3'b001 << s;
        wr(REG, {2'b00, e[2:0], 3'b000}, p);
        fire(v);
        check("R7 irq set", {7'd0, irq}, {7'd0, |(v & e[2:0])});
        rd(REG, d);
        check("R5 status read", d, {2'b00, e[2:0], v});
        check("R7 irq cleared", {7'd0, irq}, 8'd0);
        rd(REG, d);
        check("R5 cleared", d, {2'b00, e[2:0], 3'b000});
      end
    end

    // R8: event under read
    wr(REG, 8'h38, p);
    fire(3'b010);
    @(negedge clk);
    bus_addr = REG; bus_rd = 1'b1; ev_parity = 1'b1;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; ev_parity = 1'b0;
    check("R8 read during event", d, 8'h3A);
    check("R8 irq stays", {7'd0, irq}, 8'd1);
    rd(REG, d); check("R8 flag kept", d, 8'h3C);

    // R2: fifo reset command edge
    wr(REG, 8'h80, p); check("R2 pulse on rise", {7'd0, p}, 8'd1);
    @(negedge clk); check("R2 pulse one cycle", {7'd0, fifo_rst_pulse}, 8'd0);
    wr(REG, 8'h80, p); check("R2 no pulse on 1 to 1", {7'd0, p}, 8'd0);
    rd(REG, d); check("R2 readback", d, 8'h80);
    wr(REG, 8'h00, p);
    wr(REG, 8'h80, p); check("R2 second rise", {7'd0, p}, 8'd1);

    // R10: foreign address
    wr(REG, 8'h28, p);
    fire(3'b100);
    wr(8'h6F, 8'hFF, p); check("R10 foreign write no pulse", {7'd0, p}, 8'd0);
    rd(8'h6F, d); check("R10 foreign rdata", d, 8'h00);
    check("R10 irq kept", {7'd0, irq}, 8'd1);
    rd(REG, d); check("R10 reg intact", d, 8'h2C);

    // R9: other mode
    wr(REG, 8'h00, p);
    cell_mode = 1'b0;
    wr(REG, 8'hF8, p); check("R9 no pulse", {7'd0, p}, 8'd0);
    check("R9 discard low", {7'd0, discard_on_perr}, 8'd0);
    fire(3'b111);
    check("R9 irq low", {7'd0, irq}, 8'd0);
    rd(REG, d); check("R9 no status", d, 8'hF8);
    cell_mode = 1'b1;
    @(negedge clk);
    check("R9 discard returns", {7'd0, discard_on_perr}, 8'd1);
    rd(REG, d); check("R9 still clear", d, 8'hF8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule